// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block behaves as the device end of a serial EEPROM reached over a four-wire SPI link (mode 0). Its chip select, serial clock, data input and active-low hold lines are brought into the system clock domain through two-stage synchronizers. Rising edges of the synchronized serial clock shift in an 8-bit instruction, then a 16-bit address and data bytes, or shift status or array bytes out on the data output. The storage is an inferred single-port byte RAM of `2**ADDR_W` bytes. A small status register holds a write-enable latch and two block-protect bits that fence off the top quarter, the top half or all of the array.

A host reaches the block as it would reach a discrete serial memory. It sets the write-enable latch and then sends write bursts, which wrap inside a 128-byte page. Read bursts run on through the whole array. The host raises chip select to end every command.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset the status byte reads 0x00, the data output is high, and the block waits for an instruction.
- R2: Chip select going high while hold is high ends the current command. The data output goes high, and the partial bit count and instruction are discarded, so the next low period starts a new instruction.
- R3: While hold is low, serial clock edges, data bits and chip select changes have no effect on the block's state.
- R4: Instruction 0x06 sets status bit 1 (the write-enable latch) and instruction 0x04 clears it. After either one, further clocks are ignored until chip select rises.
- R5: Instruction 0x05 shifts out the status byte, and keeps repeating the same byte for as long as clocks continue.
- R6: Instruction 0x01 takes one data byte and copies its bits 3:2 into status bits 3:2. It keeps status bit 1, forces the other bits to zero, and acts whether or not the latch is set.
- R7: Instruction 0x03 is followed by a 16-bit address, sent MSB first, of which only the low ADDR_W bits are used. Array bytes then stream out, and the address increments and wraps from the top of the array to 0.
- R8: Instruction 0x02 is followed by a 16-bit address, masked as in R7. Each complete data byte is stored only while the write-enable latch is set, and the latch stays set after the write.
- R9: Block-protect value status[3:2]=01 rejects writes to the top quarter of the array, 10 rejects writes to the top half, 11 rejects all writes, and 00 rejects none. With ADDR_W=10 the limits are 0x300 and 0x200.
- R10: After each written byte, only the low 7 address bits increment, wrapping within a 128-byte page. The upper address bits stay fixed.
- R11: Any other instruction leaves the data output high and ignores clocks until chip select rises.
- R12: Input bits are taken MSB first on serial clock rising edges. Output bits change only on rising edges in a read phase, MSB first, or go high when chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock; each phase must last at least 3 system clocks |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low hold; low freezes the block |
| so | output | 1 | Serial data out |

## Verification
The hardest case to reach is a hold pulse in the middle of a data byte. The bench shifts in half of a write byte, drops hold, clocks several zero bits with hold low, then releases hold and sends the remaining bits. The stored byte shows whether the frozen edges were counted. Protection limits are probed with known bytes written on both sides of each fence, and the block-protect value is then raised step by step. Masking and wrap are tested with a read that sets unused high address bits and crosses the page boundary, and with a read that starts at the top address and wraps to 0.

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic so
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;

  typedef enum logic [2:0] {S_OPC = 3'd0, S_ADR = 3'd1, S_WR = 3'd2, S_RD = 3'd3, S_IDLE = 3'd4} st_t;

  logic [1:0] cs_q, sck_q, si_q, hold_q;
  logic sck_d;
  logic cs_s, sck_s, si_s, hold_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 2'b11;
      sck_q <= 2'b00;
      si_q <= 2'b00;
      hold_q <= 2'b11;
      sck_d <= 1'b0;
    end else begin
      cs_q <= {cs_q[0], cs_n};
      sck_q <= {sck_q[0], sck};
      si_q <= {si_q[0], si};
      hold_q <= {hold_q[0], hold_n};
      sck_d <= sck_s;
    end
  end

  assign cs_s = cs_q[1];
  assign sck_s = sck_q[1];
  assign si_s = si_q[1];
  assign hold_s = hold_q[1];

  logic sck_rise, end_op, step;
  assign sck_rise = sck_s & ~sck_d;
  assign end_op = hold_s & cs_s;
  assign step = hold_s & ~cs_s & sck_rise;

  st_t st;
  logic [3:0] cnt;
  logic [7:0] opc;
  logic [ADDR_W-1:0] asr, addr;
  logic [6:0] wbuf;
  logic [7:0] status;
  logic [7:0] rd_q;
  logic [7:0] mem [DEPTH];

  logic [7:0] opc_n, wb_n, rd_src;
  logic [ADDR_W-1:0] asr_n;
  logic last8, last16, blocked, mem_we;

  assign opc_n = {opc[6:0], si_s};
  assign asr_n = {asr[ADDR_W-2:0], si_s};
  assign wb_n = {wbuf, si_s};
  assign last8 = (cnt == 4'd7);
  assign last16 = (cnt == 4'd15);
  assign rd_src = (opc == OP_READ) ? rd_q : status;

  always_comb begin
    case (status[3:2])
      2'b01: blocked = (addr[ADDR_W-1:ADDR_W-2] == 2'b11);
      2'b10: blocked = addr[ADDR_W-1];
      2'b11: blocked = 1'b1;
      default: blocked = 1'b0;
    endcase
  end

  assign mem_we = step && (st == S_WR) && last8 && (opc == OP_WRITE) && status[1] && !blocked;

  always_ff @(posedge clk) begin
    if (mem_we) mem[addr] <= wb_n;
    rd_q <= mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OPC;
      cnt <= '0;
      opc <= '0;
      asr <= '0;
      addr <= '0;
      wbuf <= '0;
      status <= '0;
      so <= 1'b1;
    end else if (end_op) begin
      st <= S_OPC;
      cnt <= '0;
      opc <= '0;
      so <= 1'b1;
    end else if (step) begin
      case (st)
        S_OPC: begin
          opc <= opc_n;
          cnt <= last8 ? 4'd0 : cnt + 4'd1;
          if (last8) begin
            case (opc_n)
              OP_WRSR: begin wbuf <= '0; st <= S_WR; end
              OP_WRITE, OP_READ: st <= S_ADR;
              OP_WRDI: begin status[1] <= 1'b0; st <= S_IDLE; end
              OP_RDSR: st <= S_RD;
              OP_WREN: begin status[1] <= 1'b1; st <= S_IDLE; end
              default: st <= S_IDLE;
            endcase
          end
        end
        S_ADR: begin
          asr <= asr_n;
          cnt <= last16 ? 4'd0 : cnt + 4'd1;
          if (last16) begin
            addr <= asr_n;
            wbuf <= '0;
            st <= opc[0] ? S_RD : S_WR;
          end
        end
        S_WR: begin
          wbuf <= wb_n[6:0];
          cnt <= last8 ? 4'd0 : cnt + 4'd1;
          if (last8) begin
            if (opc == OP_WRSR) begin
              status <= {4'b0000, wb_n[3:2], status[1], 1'b0};
              st <= S_IDLE;
            end else begin
              addr <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
            end
          end
        end
        S_RD: begin
          so <= rd_src[~cnt[2:0]];
          cnt <= last8 ? 4'd0 : cnt + 4'd1;
          if (last8 && opc == OP_READ) addr <= addr + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

module spi_eeprom_slave_chk #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 7
) (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic hold_s,
  input logic sck_rise,
  input logic so,
  input logic [2:0] st_code,
  input logic [7:0] status,
  input logic [ADDR_W-1:0] addr
);
  p_cs_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && hold_s) |=> (so && st_code == 3'd0));

  p_hold_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_s |=> ($stable(so) && $stable(st_code) && $stable(status) && $stable(addr)));

  p_so_on_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (so != $past(so)) |-> $past(sck_rise || (cs_s && hold_s)));

  p_status_unused_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7:4] == 4'b0000 && status[0] == 1'b0));

  p_page_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code == 3'd2) |=> (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])));
endmodule

bind spi_eeprom_slave spi_eeprom_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .cs_s(cs_s),
  .hold_s(hold_s),
  .sck_rise(sck_rise),
  .so(so),
  .st_code(st),
  .status(status),
  .addr(addr)
);

// File: tb/sim_spi_eeprom_slave.sv
`timescale 1ns/1ps
module sim_spi_eeprom_slave;
  localparam int HP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic hold_n = 1'b1;
  logic so;

  int checks = 0;
  int fails = 0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always #5 clk = ~clk;

  spi_eeprom_slave u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n), .so(so));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_hp(input int n);
    repeat (n * HP) @(negedge clk);
  endtask

  task automatic xbit(input logic b, output logic r);
    si = b;
    sck = 1'b0;
    wait_hp(1);
    sck = 1'b1;
    wait_hp(1);
    r = so;
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      xbit(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    wait_hp(1);
  endtask

  task automatic cs_hi();
    sck = 1'b0;
    wait_hp(1);
    cs_n = 1'b1;
    wait_hp(3);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d;
    cs_lo();
    xbyte(op, d);
    cs_hi();
  endtask

  task automatic wr(input logic [15:0] a, input int n);
    logic [7:0] d;
    cs_lo();
    xbyte(8'h02, d);
    xbyte(a[15:8], d);
    xbyte(a[7:0], d);
    for (int i = 0; i < n; i++) xbyte(wbuf[i], d);
    cs_hi();
  endtask

  task automatic rd(input logic [15:0] a, input int n);
    logic [7:0] d;
    cs_lo();
    xbyte(8'h03, d);
    xbyte(a[15:8], d);
    xbyte(a[7:0], d);
    for (int i = 0; i < n; i++) xbyte(8'h00, rbuf[i]);
    cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] s0, output logic [7:0] s1);
    logic [7:0] d;
    cs_lo();
    xbyte(8'h05, d);
    xbyte(8'h00, s0);
    xbyte(8'h00, s1);
    cs_hi();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    cs_lo();
    xbyte(8'h01, d);
    xbyte(v, d);
    cs_hi();
  endtask

  task automatic t_reset();
    logic [7:0] s0, s1;
    check("R1 so after reset", {7'd0, so}, 8'h01);
    rdsr(s0, s1);
    check("R1 status after reset", s0, 8'h00);
  endtask

  task automatic t_wel();
    logic [7:0] s0, s1;
    cmd(8'h06);
    rdsr(s0, s1);
    check("R4 wren sets latch", s0, 8'h02);
    check("R5 status byte repeats", s1, 8'h02);
    cmd(8'h04);
    rdsr(s0, s1);
    check("R4 wrdi clears latch", s0, 8'h00);
  endtask

  task automatic t_write_gate();
    logic [7:0] s0, s1;
    cmd(8'h06);
    wbuf[0] = 8'h55; wr(16'h0010, 1);
    wbuf[0] = 8'h66; wr(16'h0011, 1);
    rdsr(s0, s1);
    check("R8 latch kept after write", s0, 8'h02);
    cmd(8'h04);
    wbuf[0] = 8'hAA; wr(16'h0010, 1);
    rd(16'h0010, 2);
    check("R8 write blocked without latch", rbuf[0], 8'h55);
    check("R8 second write with same latch", rbuf[1], 8'h66);
  endtask

  task automatic t_page_wrap();
    cmd(8'h06);
    wbuf[0] = 8'h5A; wr(16'h0080, 1);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    wr(16'h007E, 4);
    rd(16'h007E, 2);
    check("R10 byte at 0x07E", rbuf[0], 8'h11);
    check("R10 byte at 0x07F", rbuf[1], 8'h22);
    rd(16'h0000, 2);
    check("R10 wrapped to 0x000", rbuf[0], 8'h33);
    check("R10 wrapped to 0x001", rbuf[1], 8'h44);
    rd(16'h0080, 1);
    check("R10 next page untouched", rbuf[0], 8'h5A);
  endtask

  task automatic t_read_wrap_mask();
    wbuf[0] = 8'hC3; wr(16'h03FF, 1);
    rd(16'hFC7E, 3);
    check("R7 masked address 0x07E", rbuf[0], 8'h11);
    check("R7 sequential 0x07F", rbuf[1], 8'h22);
    check("R12 R7 read crosses page", rbuf[2], 8'h5A);
    rd(16'h03FF, 2);
    check("R7 top byte", rbuf[0], 8'hC3);
    check("R7 read wraps to 0", rbuf[1], 8'h33);
  endtask

  task automatic t_wrsr();
    logic [7:0] s0, s1;
    cmd(8'h06);
    wrsr(8'hFF);
    rdsr(s0, s1);
    check("R6 wrsr keeps latch and bits 3:2", s0, 8'h0E);
    cmd(8'h04);
    wrsr(8'hF3);
    rdsr(s0, s1);
    check("R6 wrsr acts without latch", s0, 8'h00);
  endtask

  task automatic t_protect();
    logic [7:0] s0, s1;
    cmd(8'h06);
    wbuf[0] = 8'h11; wr(16'h0300, 1);
    wbuf[0] = 8'h22; wr(16'h02FF, 1);
    wbuf[0] = 8'h33; wr(16'h0200, 1);
    wbuf[0] = 8'h44; wr(16'h01FF, 1);
    wbuf[0] = 8'h66; wr(16'h0100, 1);
    wrsr(8'h04);
    rdsr(s0, s1);
    check("R9 status with bp=01", s0, 8'h06);
    wbuf[0] = 8'hA1; wr(16'h0300, 1);
    wbuf[0] = 8'hA2; wr(16'h02FF, 1);
    rd(16'h0300, 1);
    check("R9 bp=01 blocks 0x300", rbuf[0], 8'h11);
    rd(16'h02FF, 1);
    check("R9 bp=01 allows 0x2FF", rbuf[0], 8'hA2);
    wrsr(8'h08);
    wbuf[0] = 8'hA3; wr(16'h0200, 1);
    wbuf[0] = 8'hA4; wr(16'h01FF, 1);
    wbuf[0] = 8'hB2; wr(16'h02FF, 1);
    rd(16'h01FF, 3);
    check("R9 bp=10 allows 0x1FF", rbuf[0], 8'hA4);
    check("R9 bp=10 blocks 0x200", rbuf[1], 8'h33);
    rd(16'h02FF, 1);
    check("R9 bp=10 blocks 0x2FF", rbuf[0], 8'hA2);
    wrsr(8'h0C);
    wbuf[0] = 8'hA5; wr(16'h0100, 1);
    rd(16'h0100, 1);
    check("R9 bp=11 blocks all", rbuf[0], 8'h66);
    wrsr(8'h00);
    wbuf[0] = 8'hA6; wr(16'h0100, 1);
    rd(16'h0100, 1);
    check("R9 bp=00 allows all", rbuf[0], 8'hA6);
  endtask

  task automatic t_unknown();
    logic [7:0] d, s0, s1;
    cs_lo();
    xbyte(8'h9C, d);
    xbyte(8'h00, d);
    cs_hi();
    check("R11 unknown opcode keeps so high", d, 8'hFF);
    rdsr(s0, s1);
    check("R11 status unchanged", s0, 8'h02);
  endtask

  task automatic t_hold();
    logic [7:0] d;
    logic r;
    cs_lo();
    xbyte(8'h02, d);
    xbyte(8'h01, d);
    xbyte(8'h23, d);
    xbit(1'b1, r); xbit(1'b0, r); xbit(1'b1, r); xbit(1'b1, r);
    sck = 1'b0;
    wait_hp(1);
    hold_n = 1'b0;
    wait_hp(1);
    for (int i = 0; i < 3; i++) xbit(1'b0, r);
    sck = 1'b0;
    wait_hp(1);
    hold_n = 1'b1;
    wait_hp(1);
    xbit(1'b0, r); xbit(1'b1, r); xbit(1'b1, r); xbit(1'b1, r);
    cs_hi();
    rd(16'h0123, 1);
    check("R3 edges during hold ignored", rbuf[0], 8'hB7);
  endtask

  task automatic t_cs_abort();
    logic [7:0] d, s0, s1;
    logic r;
    cs_lo();
    for (int i = 0; i < 4; i++) xbit(1'b0, r);
    cs_hi();
    rdsr(s0, s1);
    check("R2 partial opcode discarded", s0, 8'h02);
    cs_lo();
    xbyte(8'h03, d);
    xbyte(8'h00, d);
    xbyte(8'h11, d);
    xbyte(8'h00, d);
    check("R12 read byte before abort", d, 8'h66);
    check("R2 so low before cs rises", {7'd0, so}, 8'h00);
    cs_hi();
    check("R2 so high after cs rises", {7'd0, so}, 8'h01);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_wel();
    t_write_gate();
    t_page_wrap();
    t_read_wrap_mask();
    t_wrsr();
    t_protect();
    t_unknown();
    t_hold();
    t_cs_abort();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule